// File: doc/BRIEF.md
# Paper-tape absolute loader parser

This block sits behind a tape byte source and turns an absolute-load byte stream into memory write requests. Bytes arrive one per cycle with a valid strobe. Pairs of bytes form 16-bit words, low byte first. The parser walks leader, a six-byte header, an optional data section and an optional skip region. For every data word it issues one write request carrying an address, the data and a one-cycle strobe.

The header carries a signed word count, an origin and a stored checksum. The count selects the block type:
- A short negative count carries literal words.
- A long negative count carries one word that fills a run of addresses.
- A count of one delivers a start address.
- A positive count above one opens an error region, which is skipped.

The parser flags checksum failures, writes beyond the configured memory size, and a stream that ends inside a block. Each error is reported as a sticky code that holds until reset.

While a fill run is being written, the block raises a busy flag. The byte source must hold off while that flag is high.

Top module: `tape_loader`

## Requirements
- R1: Zero bytes seen between blocks are leader and are ignored. The first non-zero byte begins a block and is taken as the low byte of the count.
- R2: The header is count, origin and checksum, each sent low byte then high byte. A count with bit 15 set gives a length of 65536 minus the count. For a length of 1 to 20, that many words follow (low byte first) and word i is written to origin+i.
- R3: For a length above 20, one word follows. That word is written to `length` consecutive addresses starting at the origin, one write per cycle. `fill_busy_o` is high for exactly those `length` cycles, and bytes offered during them are dropped.
- R4: A count of 1 with a good checksum sets `start_valid_o` and puts the origin on `start_addr_o`. No write is issued. `start_valid_o` stays set until reset.
- R5: A count from 2 to 32767 starts a skip region. Every byte is discarded up to and including the first byte equal to 0xFF, and then leader parsing resumes.
- R6: The 16-bit sum of count, origin, stored checksum and all data words received must be zero. The check runs after the last write of a data block, or after the header for a count of 1. On failure `err_code_o` becomes 1.
- R7: A write whose address is at or above `MEM_WORDS` is not issued. Instead `err_code_o` becomes 2.
- R8: A one-cycle pulse on `end_i` sets `err_code_o` to 3 if the parser is inside a header or a data or fill section. The pulse has no effect between blocks or inside a skip region.
- R9: Once `err_code_o` is non-zero, it holds its value and no further writes are issued until reset. This holds whatever bytes arrive.
- R10: After reset, `wr_en_o`, `fill_busy_o`, `start_valid_o` and `err_code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | A byte is offered this cycle |
| byte_i | input | 8 | Tape byte |
| end_i | input | 1 | End-of-stream pulse |
| wr_en_o | output | 1 | Write request strobe, one cycle |
| wr_addr_o | output | 16 | Write address |
| wr_data_o | output | 16 | Write data |
| fill_busy_o | output | 1 | Fill run in progress; the source must not offer bytes |
| start_valid_o | output | 1 | A start address has been loaded |
| start_addr_o | output | 16 | Loaded start address |
| err_code_o | output | 2 | 0 none, 1 checksum, 2 out of range, 3 truncated stream |

## Verification
The bench targets the literal/fill boundary at lengths 20 and 21. A parser that picks the wrong side either expects 21 data words or fills 20 addresses.

It ends runs of writes right at the top of memory. A wrong bound check would write past the limit or stop one word early.

Checksum failures are placed after the last data word. The bench then sends another valid block, which would show writes leaking out after a sticky error.

End-of-stream pulses are given between blocks, in a skip region and inside a header. These catch a parser that flags a format error in the wrong states. Skip regions filled with non-0xFF junk expose a parser that resumes too early.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_CNT_HI, S_ORG_LO, S_ORG_HI, S_SUM_LO, S_SUM_HI,
    S_DAT_LO, S_DAT_HI, S_FILL, S_SKIP, S_HALT
  } tl_state_e;

  typedef enum logic [1:0] {
    E_NONE = 2'd0, E_SUM = 2'd1, E_NXM = 2'd2, E_FMT = 2'd3
  } tl_err_e;
endpackage

// File: rtl/tl_pair.sv
module tl_pair
  import tl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] word_o
);
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      lo_q <= '0;
    else if (lo_we_i) lo_q <= byte_i;

  assign word_o = {byte_i, lo_q};
endmodule

// File: rtl/tl_sum.sv
module tl_sum
  import tl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              add_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              next_zero_o,
  output logic              sum_zero_o
);
  logic [WORD_W-1:0] sum_q, sum_n;

  assign sum_n = sum_q + word_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     sum_q <= '0;
    else if (ld_i)   sum_q <= word_i;
    else if (add_i)  sum_q <= sum_n;

  assign next_zero_o = (sum_n == '0);
  assign sum_zero_o  = (sum_q == '0);
endmodule

// File: rtl/tl_origin.sv
module tl_origin
  import tl_pkg::*;
#(
  parameter int MEM_WORDS = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              inc_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] origin_o,
  output logic              oob_o
);
  localparam logic [WORD_W:0] LIMIT = (WORD_W+1)'(MEM_WORDS);
  logic [WORD_W-1:0] org_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     org_q <= '0;
    else if (ld_i)   org_q <= word_i;
    else if (inc_i)  org_q <= org_q + 1'b1;

  assign origin_o = org_q;
  assign oob_o    = ({1'b0, org_q} >= LIMIT);
endmodule

// File: rtl/tape_loader.sv
module tape_loader
  import tl_pkg::*;
#(
  parameter int MEM_WORDS = 32768,
  parameter int LIT_MAX   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              end_i,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              fill_busy_o,
  output logic              start_valid_o,
  output logic [WORD_W-1:0] start_addr_o,
  output logic [1:0]        err_code_o
);
  localparam logic [WORD_W-1:0] LIT_LIM = WORD_W'(LIT_MAX);

  tl_state_e         state_q, state_d;
  tl_err_e           err_q, err_d;
  logic [WORD_W-1:0] cnt_q, cnt_d, len_q, len_d, rep_q, rep_d;
  logic [WORD_W-1:0] waddr_q, waddr_d, wdata_q, wdata_d, start_q, start_d;
  logic              wr_q, wr_d, sv_q, sv_d;
  logic [WORD_W-1:0] word, origin;
  logic              take, lo_we, sum_ld, sum_add, next_zero, sum_zero;
  logic              org_ld, org_inc, oob;

  assign take  = byte_valid_i && !end_i && state_q != S_FILL && state_q != S_HALT;
  assign lo_we = take && (state_q == S_IDLE || state_q == S_ORG_LO ||
                          state_q == S_SUM_LO || state_q == S_DAT_LO);
  assign sum_ld  = take && state_q == S_CNT_HI;
  assign sum_add = take && (state_q == S_ORG_HI || state_q == S_SUM_HI ||
                            state_q == S_DAT_HI);
  assign org_ld  = take && state_q == S_ORG_HI;

  tl_pair u_pair (
    .clk_i, .rst_ni, .lo_we_i(lo_we), .byte_i, .word_o(word)
  );

  tl_sum u_sum (
    .clk_i, .rst_ni, .ld_i(sum_ld), .add_i(sum_add), .word_i(word),
    .next_zero_o(next_zero), .sum_zero_o(sum_zero)
  );

  tl_origin #(.MEM_WORDS(MEM_WORDS)) u_org (
    .clk_i, .rst_ni, .ld_i(org_ld), .inc_i(org_inc), .word_i(word),
    .origin_o(origin), .oob_o(oob)
  );

  always_comb begin
    state_d = state_q;  err_d   = err_q;
    cnt_d   = cnt_q;    len_d   = len_q;   rep_d = rep_q;
    waddr_d = waddr_q;  wdata_d = wdata_q; wr_d  = 1'b0;
    sv_d    = sv_q;     start_d = start_q; org_inc = 1'b0;
    if (end_i && state_q != S_IDLE && state_q != S_SKIP && state_q != S_HALT) begin
      err_d = E_FMT; state_d = S_HALT;
    end else if (state_q == S_FILL) begin
      if (oob) begin
        err_d = E_NXM; state_d = S_HALT;
      end else begin
        wr_d = 1'b1; waddr_d = origin; wdata_d = rep_q;
        org_inc = 1'b1; len_d = len_q - 1'b1;
        if (len_q == 16'd1) begin
          if (sum_zero) state_d = S_IDLE;
          else begin err_d = E_SUM; state_d = S_HALT; end
        end
      end
    end else if (take) begin
      unique case (state_q)
        S_IDLE:   if (byte_i != '0) state_d = S_CNT_HI;
        S_CNT_HI: begin cnt_d = word; state_d = S_ORG_LO; end
        S_ORG_LO: state_d = S_ORG_HI;
        S_ORG_HI: state_d = S_SUM_LO;
        S_SUM_LO: state_d = S_SUM_HI;
        S_SUM_HI: begin
          if (cnt_q[WORD_W-1:1] == '0) begin
            if (!next_zero) begin
              err_d = E_SUM; state_d = S_HALT;
            end else begin
              if (cnt_q[0]) begin sv_d = 1'b1; start_d = origin; end
              state_d = S_IDLE;
            end
          end else if (!cnt_q[WORD_W-1]) begin
            state_d = S_SKIP;
          end else begin
            len_d = '0 - cnt_q; state_d = S_DAT_LO;
          end
        end
        S_DAT_LO: state_d = S_DAT_HI;
        S_DAT_HI: begin
          if (len_q > LIT_LIM) begin
            rep_d = word; state_d = S_FILL;
          end else if (oob) begin
            err_d = E_NXM; state_d = S_HALT;
          end else begin
            wr_d = 1'b1; waddr_d = origin; wdata_d = word;
            org_inc = 1'b1; len_d = len_q - 1'b1;
            if (len_q == 16'd1) begin
              if (next_zero) state_d = S_IDLE;
              else begin err_d = E_SUM; state_d = S_HALT; end
            end else state_d = S_DAT_LO;
          end
        end
        S_SKIP:   if (byte_i == 8'hFF) state_d = S_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= S_IDLE; err_q <= E_NONE;
      cnt_q <= '0; len_q <= '0; rep_q <= '0;
      waddr_q <= '0; wdata_q <= '0; wr_q <= 1'b0;
      sv_q <= 1'b0; start_q <= '0;
    end else begin
      state_q <= state_d; err_q <= err_d;
      cnt_q <= cnt_d; len_q <= len_d; rep_q <= rep_d;
      waddr_q <= waddr_d; wdata_q <= wdata_d; wr_q <= wr_d;
      sv_q <= sv_d; start_q <= start_d;
    end

  assign wr_en_o       = wr_q;
  assign wr_addr_o     = waddr_q;
  assign wr_data_o     = wdata_q;
  assign fill_busy_o   = (state_q == S_FILL);
  assign start_valid_o = sv_q;
  assign start_addr_o  = start_q;
  assign err_code_o    = err_q;
endmodule

// File: rtl/tape_loader_chk.sv
module tape_loader_chk #(
  parameter int MEM_WORDS = 32768
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_o,
  input logic [15:0] wr_addr_o,
  input logic [15:0] wr_data_o,
  input logic        start_valid_o,
  input logic [1:0]  err_code_o
);
  localparam logic [16:0] LIMIT = 17'(MEM_WORDS);

  // R7
  wr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ({1'b0, wr_addr_o} < LIMIT));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o != 2'd0) |=> $stable(err_code_o));

  // R9
  no_wr_after_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o != 2'd0) |=> !wr_en_o);

  // R3
  fill_addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 16'd1));

  // R3
  fill_data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> $stable(wr_data_o));

  // R4
  start_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_o |=> start_valid_o);
endmodule

bind tape_loader tape_loader_chk #(.MEM_WORDS(MEM_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .wr_data_o(wr_data_o), .start_valid_o(start_valid_o), .err_code_o(err_code_o)
);

// File: tb/tape_loader_bench.sv
module tape_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM = 32768;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, eos = 1'b0;
  logic [7:0] dat = '0;
  logic wr_en_o, fill_busy_o, start_valid_o;
  logic [15:0] wr_addr_o, wr_data_o, start_addr_o;
  logic [1:0] err_code_o;

  int checks = 0, failures = 0, busy_cyc = 0;
  bit done = 0;
  logic [31:0] cap_q[$], exp_q[$];
  logic [15:0] blk_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_loader #(.MEM_WORDS(MEM)) u_tape_loader (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(vld), .byte_i(dat), .end_i(eos),
    .wr_en_o, .wr_addr_o, .wr_data_o, .fill_busy_o, .start_valid_o,
    .start_addr_o, .err_code_o
  );

  always @(negedge clk) if (rst_n) begin
    if (wr_en_o) cap_q.push_back({wr_addr_o, wr_data_o});
    if (fill_busy_o) busy_cyc++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vld = 1'b0; eos = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cap_q.delete(); exp_q.delete(); busy_cyc = 0;
  endtask

  task automatic put(input logic [7:0] b);
    while (fill_busy_o) @(negedge clk);
    vld = 1'b1; dat = b;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic put_word(input logic [15:0] w);
    put(w[7:0]); put(w[15:8]);
  endtask

  task automatic pulse_end();
    eos = 1'b1; @(negedge clk); eos = 1'b0;
  endtask

  task automatic settle();
    while (fill_busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] sum_of(input logic [15:0] cnt, input logic [15:0] org);
    logic [15:0] s = cnt + org;
    foreach (blk_q[i]) s += blk_q[i];
    return 16'd0 - s;
  endfunction

  // header + blk_q payload; expected writes from length and origin
  task automatic send_block(input logic [15:0] cnt, input logic [15:0] org, input bit bad);
    logic [15:0] cs = sum_of(cnt, org) ^ {15'd0, bad};
    int lead = $urandom_range(0, 3);
    for (int i = 0; i < lead; i++) put(8'h00);
    put_word(cnt); put_word(org); put_word(cs);
    if (cnt[15]) begin
      int len = 65536 - int'(cnt);
      for (int i = 0; i < len; i++) begin
        if (int'(org) + i >= MEM) break;
        exp_q.push_back({org + 16'(i), (len > 20) ? blk_q[0] : blk_q[i]});
      end
      foreach (blk_q[i]) put_word(blk_q[i]);
    end
  endtask

  task automatic data_block(input int len, input logic [15:0] org, input bit bad);
    blk_q.delete();
    for (int i = 0; i < ((len > 20) ? 1 : len); i++) blk_q.push_back(16'($urandom));
    send_block(16'(65536 - len), org, bad);
  endtask

  task automatic skip_block(input int junk);
    blk_q.delete();
    send_block({1'b0, 7'($urandom_range(1, 127)), 8'($urandom_range(2, 255))},
               16'($urandom), 1'b0);
    for (int i = 0; i < junk; i++) put(8'($urandom_range(0, 254)));
    put(8'hFF);
  endtask

  task automatic cmp_writes(input string tag);
    bool_chk: begin
      bit ok = (cap_q.size() == exp_q.size());
      int bad_i = -1;
      if (ok) foreach (exp_q[i]) if (ok && cap_q[i] !== exp_q[i]) begin ok = 0; bad_i = i; end
      if (bad_i >= 0) chk(ok, tag, int'(cap_q[bad_i]), int'(exp_q[bad_i]));
      else chk(ok, {tag, " count"}, cap_q.size(), exp_q.size());
    end
    cap_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_start;
    bit exp_sv;
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    do_reset();
    // R10 reset state
    chk(wr_en_o == 0 && fill_busy_o == 0, "R10 wr/busy", {wr_en_o, fill_busy_o}, 0);
    chk(start_valid_o == 0 && err_code_o == 0, "R10 start/err", {start_valid_o, err_code_o}, 0);

    // R1 R2 literal block with leader
    for (int i = 0; i < 5; i++) put(8'h00);
    data_block(3, 16'h0100, 0);
    for (int i = 0; i < 4; i++) put(8'h00);
    settle();
    cmp_writes("R1 R2 literal len3");

    // R2 boundary length 20
    data_block(20, 16'h0200, 0); settle();
    cmp_writes("R2 literal len20");

    // R3 length 21 fill, busy cycles
    busy_cyc = 0;
    data_block(21, 16'h0300, 0); settle();
    chk(busy_cyc == 21, "R3 busy cycles", busy_cyc, 21);
    cmp_writes("R3 fill len21");

    // R3 bytes during fill dropped: next block still parses
    data_block(40, 16'h0400, 0);
    vld = 1'b1; dat = 8'h5A; @(negedge clk); @(negedge clk); vld = 1'b0;
    settle();
    data_block(2, 16'h0500, 0); settle();
    cmp_writes("R3 fill drop bytes");

    // R4 start address
    blk_q.delete(); send_block(16'd1, 16'h1234, 0); settle();
    chk(start_valid_o && start_addr_o == 16'h1234, "R4 start addr", start_addr_o, 16'h1234);
    cmp_writes("R4 no writes");

    // R5 skip region then good block
    skip_block(6);
    data_block(4, 16'h0600, 0); settle();
    cmp_writes("R5 skip then literal");
    chk(err_code_o == 0, "R5 err", err_code_o, 0);

    // R8 end pulse between blocks and inside skip
    pulse_end();
    chk(err_code_o == 0, "R8 end idle", err_code_o, 0);
    blk_q.delete(); send_block(16'h0042, 16'h0000, 0); put(8'h11);
    pulse_end(); put(8'hFF); settle();
    chk(err_code_o == 0, "R8 end in skip", err_code_o, 0);

    // R2 R3 R4 R5 random mix
    exp_sv = start_valid_o; exp_start = start_addr_o;
    for (int r = 0; r < 4; r++) begin
      for (int b = 0; b < 8; b++) begin
        case ($urandom_range(0, 3))
          0: data_block($urandom_range(1, 20), 16'($urandom_range(0, 16'h7000)), 0);
          1: data_block($urandom_range(21, 60), 16'($urandom_range(0, 16'h7000)), 0);
          2: begin
               exp_start = 16'($urandom); exp_sv = 1;
               blk_q.delete(); send_block(16'd1, exp_start, 0);
             end
          default: skip_block($urandom_range(0, 5));
        endcase
      end
      settle();
      cmp_writes("R2 R3 random round");
      chk(err_code_o == 0, "R5 random err", err_code_o, 0);
      chk(start_valid_o == exp_sv && start_addr_o == exp_start, "R4 random start",
          start_addr_o, exp_start);
    end

    // R6 checksum error at end of literal, then R9 sticky
    do_reset();
    data_block(2, 16'h0700, 1); settle();
    chk(err_code_o == 1, "R6 literal sum", err_code_o, 1);
    cmp_writes("R6 writes before check");
    data_block(3, 16'h0800, 0); settle();
    exp_q.delete();
    chk(err_code_o == 1, "R9 sticky code", err_code_o, 1);
    cmp_writes("R9 no writes after err");

    // R6 fill checksum error
    do_reset();
    data_block(25, 16'h0900, 1); settle();
    chk(err_code_o == 1, "R6 fill sum", err_code_o, 1);
    cmp_writes("R6 fill writes");

    // R4 R6 bad start block
    do_reset();
    blk_q.delete(); send_block(16'd1, 16'h0ABC, 1); settle();
    chk(err_code_o == 1 && !start_valid_o, "R4 R6 bad start", {start_valid_o, err_code_o}, 1);

    // R7 literal crossing top
    do_reset();
    data_block(3, 16'(MEM - 2), 0); settle();
    chk(err_code_o == 2, "R7 literal nxm", err_code_o, 2);
    cmp_writes("R7 literal writes");

    // R7 fill crossing top
    do_reset();
    data_block(30, 16'(MEM - 5), 0); settle();
    chk(err_code_o == 2, "R7 fill nxm", err_code_o, 2);
    cmp_writes("R7 fill writes");

    // R8 end inside header
    do_reset();
    put(8'h05); put(8'h00); put(8'h10);
    pulse_end(); settle();
    chk(err_code_o == 3, "R8 end header", err_code_o, 3);

    // R8 end inside data, R9 then bytes ignored
    do_reset();
    blk_q.delete(); blk_q.push_back(16'h1111); blk_q.push_back(16'h2222);
    put_word(16'hFFFE); put_word(16'h0010); put_word(sum_of(16'hFFFE, 16'h0010));
    put_word(16'h1111); put(8'h22);
    pulse_end(); put(8'h22); settle();
    chk(err_code_o == 3, "R8 end data", err_code_o, 3);
    exp_q.delete(); exp_q.push_back({16'h0010, 16'h1111});
    cmp_writes("R9 writes after end");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule